// File: doc/BRIEF.md
# Calendar timekeeper with deferred-commit write handshake

This block keeps wall-clock time and calendar date in two register-mapped words, one for time of day and one for date, both readable at any moment over a simple register port. A one-second tick pulse, already brought into the bus clock as a single-cycle strobe, advances the time of day. The carry out of 23:59:59 advances the date through month lengths, a software-supplied leap flag and a six-bit year offset. Both words change on the same bus-clock edge, so software that reads them twice and gets matching values has a consistent pair.

Writes to the time or date word do not land at once. Each one is held and handed to a slow timing domain, represented by a strobe that marks each slow-clock edge. The word takes the new value only after a fixed number of slow edges. While a write waits, a busy bit for that word reads as set in the control register, and further writes to that word are dropped. The control register also holds an oscillator-select bit. That bit changes only when the write carries a 16-bit key in its upper half.

Top module: `cal_keeper`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00000101 (day 1, month 1, year offset 0, leap 0), the control register reads 0 and `osc_sel` is 0.
- R2: A write to the time word (offset 0x14) while it is not busy makes control bit 8 read 1 from the next cycle. A write to the date word (offset 0x10) does the same for control bit 7. Control bit 9 always reads 0.
- R3: A pending word keeps its old contents until COMMIT_SLOW `slow_en` strobes have been seen after the write. On the bus-clock edge after the edge that samples the last of those strobes, the word takes the written value and its busy bit returns to 0.
- R4: A write to a word whose busy bit is set is ignored. The value that lands is the one from the earlier write, and the commit timing is unchanged.
- R5: A write to the control register (offset 0x00) updates `osc_sel` and control bit 0 from write-data bit 0 only when write-data bits 31:16 equal 0x16AA. Any other key leaves them unchanged.
- R6: The time word holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. The date word holds day in bits 4:0, month in bits 11:8, year offset in bits 21:16 and the leap flag in bit 22. All other bits are discarded on write and read as 0.
- R7: On a tick, seconds at 59 wrap to 0 and carry into minutes. Minutes at 59 wrap to 0 and carry into hours. Hours at 23 wrap to 0 and carry into the date.
- R8: A date carry advances the day. The day wraps to 1 and the month advances after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12.
- R9: In month 2 the last day is 28 when the leap flag is 0 and 29 when it is 1.
- R10: When the day wraps in month 12, the month becomes 1 and the year offset increments modulo 64, so 63 goes to 0. The leap flag is never changed by rollover.
- R11: A tick updates both words on the edge that samples it, and reads return the live contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sec_tick | input | 1 | One-cycle strobe per second |
| slow_en | input | 1 | One-cycle strobe per slow-domain clock edge |
| osc_sel | output | 1 | 1 selects the external oscillator, 0 the internal one |

## Verification
The bench uses the default COMMIT_SLOW of 3. This keeps each commit short enough that dozens of random time and date pairs can be loaded and ticked. It is still long enough to probe the word and its busy bit after two strobes, before the commit, and to slip a rejected second write into that window. The six-bit year field is small enough that the wrap from offset 63 to 0 is reached directly. The random pairs are biased toward field maxima, so carries through every field and every month length appear often.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    typedef struct packed {
        logic       leap;
        logic [5:0] year;
        logic [3:0] month;
        logic [4:0] day;
    } ymd_t;

    function automatic logic [31:0] tod_to_word(tod_t t);
        return {11'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
    endfunction

    function automatic tod_t word_to_tod(logic [31:0] w);
        tod_t t;
        t.hour = w[20:16];
        t.min  = w[13:8];
        t.sec  = w[5:0];
        return t;
    endfunction

    function automatic logic [31:0] ymd_to_word(ymd_t d);
        return {9'b0, d.leap, d.year, 4'b0, d.month, 3'b0, d.day};
    endfunction

    function automatic ymd_t word_to_ymd(logic [31:0] w);
        ymd_t d;
        d.leap  = w[22];
        d.year  = w[21:16];
        d.month = w[11:8];
        d.day   = w[4:0];
        return d;
    endfunction

    function automatic logic [4:0] last_day(logic [3:0] month, logic leap);
        logic [4:0] n;
        case (month)
            4'd2:                       n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    n = 5'd30;
            default:                    n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cal_tod_adv.sv
module cal_tod_adv
    import cal_pkg::*;
(
    input  tod_t cur,
    output tod_t nxt,
    output logic carry
);
    logic sec_wrap, min_wrap, hour_wrap;

    always_comb begin
        sec_wrap  = (cur.sec  >= 6'd59);
        min_wrap  = (cur.min  >= 6'd59);
        hour_wrap = (cur.hour >= 5'd23);
        nxt       = cur;
        carry     = 1'b0;
        if (!sec_wrap) begin
            nxt.sec = cur.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (!min_wrap) begin
                nxt.min = cur.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (!hour_wrap) begin
                    nxt.hour = cur.hour + 5'd1;
                end else begin
                    nxt.hour = 5'd0;
                    carry    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cal_ymd_adv.sv
module cal_ymd_adv
    import cal_pkg::*;
(
    input  ymd_t cur,
    output ymd_t nxt
);
    logic [4:0] lim;

    always_comb begin
        lim = last_day(cur.month, cur.leap);
        nxt = cur;
        if (cur.day < lim) begin
            nxt.day = cur.day + 5'd1;
        end else begin
            nxt.day = 5'd1;
            if (cur.month < 4'd12) begin
                nxt.month = cur.month + 4'd1;
            end else begin
                nxt.month = 4'd1;
                nxt.year  = cur.year + 6'd1;
            end
        end
    end
endmodule

// File: rtl/cal_commit.sv
module cal_commit #(
    parameter int W           = 17,
    parameter int COMMIT_SLOW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] req_val,
    input  logic         slow_en,
    output logic         busy,
    output logic         load,
    output logic [W-1:0] hold
);
    localparam int CNT_W = (COMMIT_SLOW < 2) ? 1 : $clog2(COMMIT_SLOW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_SLOW - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     hold;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.done) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b0;
        end else if (s_q.busy) begin
            if (slow_en) begin
                if (s_q.cnt == LAST) s_d.done = 1'b1;
                else                 s_d.cnt  = s_q.cnt + 1'b1;
            end
        end else if (req) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.hold = req_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign load = s_q.done;
    assign hold = s_q.hold;
endmodule

// File: rtl/cal_keeper.sv
module cal_keeper
    import cal_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          COMMIT_SLOW = 3,
    parameter logic [15:0] KEY         = 16'h16AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              sec_tick,
    input  logic              slow_en,
    output logic              osc_sel
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_DATE = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] OFS_TIME = ADDR_W'(8'h14);
    localparam int TW = $bits(tod_t);
    localparam int DW = $bits(ymd_t);

    typedef struct packed {
        tod_t tod;
        ymd_t ymd;
        logic osc;
    } st_t;

    st_t s_d, s_q;

    tod_t          tod_nxt, tod_cur;
    ymd_t          ymd_nxt, ymd_cur;
    logic          tod_carry;
    logic          busy_t, busy_d, load_t, load_d;
    logic [TW-1:0] hold_t;
    logic [DW-1:0] hold_d;
    logic          wr_time, wr_date;

    assign tod_cur = s_q.tod;
    assign ymd_cur = s_q.ymd;
    assign wr_time = wr_en && (addr == OFS_TIME);
    assign wr_date = wr_en && (addr == OFS_DATE);

    cal_tod_adv u_tod (.cur(tod_cur), .nxt(tod_nxt), .carry(tod_carry));
    cal_ymd_adv u_ymd (.cur(ymd_cur), .nxt(ymd_nxt));

    cal_commit #(.W(TW), .COMMIT_SLOW(COMMIT_SLOW)) u_cm_time (
        .clk(clk), .rst_n(rst_n), .req(wr_time),
        .req_val(TW'(word_to_tod(wdata))), .slow_en(slow_en),
        .busy(busy_t), .load(load_t), .hold(hold_t)
    );

    cal_commit #(.W(DW), .COMMIT_SLOW(COMMIT_SLOW)) u_cm_date (
        .clk(clk), .rst_n(rst_n), .req(wr_date),
        .req_val(DW'(word_to_ymd(wdata))), .slow_en(slow_en),
        .busy(busy_d), .load(load_d), .hold(hold_d)
    );

    always_comb begin
        s_d = s_q;
        // a committing time word replaces the tick result, carry included
        if (load_t)        s_d.tod = tod_t'(hold_t);
        else if (sec_tick) s_d.tod = tod_nxt;

        if (load_d)                             s_d.ymd = ymd_t'(hold_d);
        else if (sec_tick && tod_carry && !load_t) s_d.ymd = ymd_nxt;

        if (wr_en && (addr == OFS_CTRL) && (wdata[31:16] == KEY))
            s_d.osc = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ymd.day   <= 5'd1;
            s_q.ymd.month <= 4'd1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL: rdata = {22'b0, 1'b0, busy_t, busy_d, 6'b0, s_q.osc};
            OFS_DATE: rdata = ymd_to_word(s_q.ymd);
            OFS_TIME: rdata = tod_to_word(s_q.tod);
            default:  rdata = 32'b0;
        endcase
    end

    assign osc_sel = s_q.osc;
endmodule

// File: rtl/cal_keeper_chk.sv
module cal_keeper_chk
    import cal_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [15:0] KEY    = 16'h16AA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              sec_tick,
    input logic              slow_en,
    input logic              osc_sel,
    input logic              busy_t,
    input logic              busy_d,
    input logic              load_t,
    input logic              load_d,
    input tod_t              tod,
    input ymd_t              ymd
);
    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h14) && !busy_t) |=> busy_t);

    p_busy_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_t) |-> $past(slow_en, 2));

    p_date_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_d) |-> $past(slow_en, 2));

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_d && !load_d) |=> busy_d);

    p_key_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == '0 && wdata[31:16] == KEY)) |=> $stable(osc_sel));

    p_sec_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && tod.sec == 6'd59 && !load_t) |=> (tod.sec == 6'd0));

    p_year_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_t && !load_d && tod.hour == 5'd23 && tod.min == 6'd59 &&
         tod.sec == 6'd59 && ymd.month == 4'd12 && ymd.day == 5'd31)
        |=> (ymd.month == 4'd1 && ymd.day == 5'd1 &&
             ymd.year == 6'($past(ymd.year) + 6'd1) && ymd.leap == $past(ymd.leap)));
endmodule

bind cal_keeper cal_keeper_chk #(.ADDR_W(ADDR_W), .KEY(KEY)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sec_tick(sec_tick), .slow_en(slow_en), .osc_sel(osc_sel),
    .busy_t(busy_t), .busy_d(busy_d), .load_t(load_t), .load_d(load_d),
    .tod(tod_cur), .ymd(ymd_cur)
);

// File: tb/cal_keeper_bench.sv
`timescale 1ns/1ps
module cal_keeper_bench;
    localparam int N = 3;

    logic        clk = 0, rst_n = 0, wr_en = 0, sec_tick = 0, slow_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        osc_sel;
    int checks = 0, errors = 0;

    cal_keeper #(.ADDR_W(8), .COMMIT_SLOW(N)) u_cal_keeper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sec_tick(sec_tick), .slow_en(slow_en), .osc_sel(osc_sel));

    always #10 clk = ~clk;

    function automatic logic [31:0] tw(int h, int m, int s);
        return (h << 16) | (m << 8) | s;
    endfunction
    function automatic logic [31:0] dw(int y, int mo, int d, int l);
        return (l << 22) | (y << 16) | (mo << 8) | d;
    endfunction
    function automatic int mdays(int mo, int l);
        if (mo == 2) return l ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    // expected {date,time} after one tick
    function automatic logic [63:0] model(logic [31:0] t, logic [31:0] d);
        int s = t[5:0], m = t[13:8], h = t[20:16];
        int dy = d[4:0], mo = d[11:8], y = d[21:16], l = d[22];
        s++;
        if (s == 60) begin s = 0; m++; end
        if (m == 60) begin m = 0; h++; end
        if (h == 24) begin
            h = 0; dy++;
            if (dy > mdays(mo, l)) begin dy = 1; mo++; end
            if (mo == 13) begin mo = 1; y = (y + 1) % 64; end
        end
        return {dw(y, mo, dy, l), tw(h, m, s)};
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask
    task automatic rd(logic [7:0] a, output logic [31:0] v);
        addr = a; #1; v = rdata;
    endtask
    task automatic wr(logic [7:0] a, logic [31:0] v);
        @(negedge clk); wr_en = 1; addr = a; wdata = v;
        @(negedge clk); wr_en = 0;
    endtask
    task automatic spulse();
        @(negedge clk); slow_en = 1;
        @(negedge clk); slow_en = 0;
    endtask
    task automatic tick();
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
    endtask
    task automatic finish_commit();
        spulse(); @(negedge clk);
    endtask
    task automatic set_both(logic [31:0] t, logic [31:0] d);
        wr(8'h14, t); wr(8'h10, d);
        for (int i = 0; i < N - 1; i++) spulse();
        finish_commit();
    endtask
    task automatic tick_check(string r, logic [31:0] t, logic [31:0] d);
        logic [63:0] e; logic [31:0] v;
        set_both(t, d);
        e = model(t, d);
        tick();
        rd(8'h14, v); chk({r, " time"}, v, e[31:0]);
        rd(8'h10, v); chk({r, " date"}, v, e[63:32]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(8'h14, v); chk("R1 time", v, 32'h0);
        rd(8'h10, v); chk("R1 date", v, 32'h101);
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        chk("R1 osc", {31'b0, osc_sel}, 32'h0);

        // R5 key guard
        wr(8'h00, 32'h16AB_0001); rd(8'h00, v); chk("R5 bad key", v, 32'h0);
        wr(8'h00, 32'h16AA_0001); rd(8'h00, v); chk("R5 good key", v, 32'h1);
        chk("R5 osc port", {31'b0, osc_sel}, 32'h1);
        wr(8'h00, 32'h0000_0000); chk("R5 no key", {31'b0, osc_sel}, 32'h1);
        wr(8'h00, 32'h16AA_FFFE); chk("R5 clear", {31'b0, osc_sel}, 32'h0);

        // R2 R3 R4 R6 time write handshake, junk bits masked
        wr(8'h14, 32'hFFE0_C0C0 | tw(23, 59, 59));
        rd(8'h00, v); chk("R2 time busy", v, 32'h100);
        wr(8'h14, tw(1, 2, 3));                       // R4 ignored
        for (int i = 0; i < N - 1; i++) spulse();
        rd(8'h14, v); chk("R3 time unchanged before commit", v, 32'h0);
        rd(8'h00, v); chk("R3 still busy", v, 32'h100);
        spulse();
        rd(8'h00, v); chk("R3 busy held one cycle", v, 32'h100);
        @(negedge clk);
        rd(8'h14, v); chk("R4 R6 committed time", v, tw(23, 59, 59));
        rd(8'h00, v); chk("R3 busy cleared", v, 32'h0);

        // R2 R3 R6 date word
        wr(8'h10, 32'hFF80_F0E0 | dw(63, 12, 31, 1));
        rd(8'h00, v); chk("R2 date busy", v, 32'h080);
        for (int i = 0; i < N - 1; i++) spulse();
        finish_commit();
        rd(8'h10, v); chk("R6 committed date", v, dw(63, 12, 31, 1));
        // R10 R11 year wrap 63 -> 0, leap kept
        tick();
        rd(8'h14, v); chk("R11 time", v, tw(0, 0, 0));
        rd(8'h10, v); chk("R10 wrap", v, dw(0, 1, 1, 1));

        tick_check("R7 plain", tw(4, 5, 6), dw(3, 3, 3, 0));
        tick_check("R7 min carry", tw(4, 59, 59), dw(3, 3, 3, 0));
        tick_check("R10 dec", tw(23, 59, 59), dw(5, 12, 31, 0));
        tick_check("R8 apr30", tw(23, 59, 59), dw(5, 4, 30, 0));
        tick_check("R8 jan30", tw(23, 59, 59), dw(5, 1, 30, 0));
        tick_check("R8 jan31", tw(23, 59, 59), dw(5, 1, 31, 0));
        tick_check("R9 feb28 noleap", tw(23, 59, 59), dw(6, 2, 28, 0));
        tick_check("R9 feb28 leap", tw(23, 59, 59), dw(6, 2, 28, 1));
        tick_check("R9 feb29 leap", tw(23, 59, 59), dw(6, 2, 29, 1));

        // random pairs biased to field maxima
        for (int k = 0; k < 40; k++) begin
            int h, m, s, mo, l, dy, y;
            h  = ($urandom % 2) ? 23 : $urandom % 24;
            m  = ($urandom % 2) ? 59 : $urandom % 60;
            s  = ($urandom % 3) ? 59 : $urandom % 60;
            mo = 1 + $urandom % 12;
            l  = $urandom % 2;
            dy = ($urandom % 2) ? mdays(mo, l) : 1 + $urandom % mdays(mo, l);
            y  = $urandom % 64;
            tick_check("R11 random", tw(h, m, s), dw(y, mo, dy, l));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule